// File: doc/BRIEF.md
# Mailbox Interrupt Controller

This block raises and drops message-passing interrupts between two ports that share one memory array. It observes, on every clock, each port's access controls (enable, write strobe, output enable), its address and the busy indication that the contention arbiter returns to that port. The topmost address of the array is the message slot owned by the right port; the address just below it is the slot owned by the left port. The message data itself lives in the shared array and is not stored here.

A write by one port into the slot owned by the other port raises the owner's interrupt. The interrupt stays raised until the owner reads its own slot. A port can look at the other port's slot without disturbing that port's interrupt. A port that the arbiter is holding off (busy active) can neither raise the other port's interrupt nor drop its own. Interrupt outputs are active low and registered, so every effect shows up on the clock edge that samples the access.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: While `rst_n` is low at a clock edge, both `lft_irq_n` and `rgt_irq_n` are 1 after that edge.
- R2: A left write (`lft_en`=1, `lft_we`=1, `lft_busy`=0) to the all-ones address drives `rgt_irq_n` to 0 after that edge.
- R3: A right write (`rgt_en`=1, `rgt_we`=1, `rgt_busy`=0) to the all-ones-minus-one address drives `lft_irq_n` to 0 after that edge.
- R4: A read by a port of its own slot (`en`=1, `we`=0, `oe`=1, `busy`=0; right slot all-ones, left slot all-ones-minus-one) drives that port's interrupt output back to 1, unless R9 applies.
- R5: A read of the other port's slot leaves that port's interrupt output unchanged.
- R6: A write to the other port's slot while the writing port's busy is 1 leaves the other port's interrupt output unchanged.
- R7: A read of its own slot while that port's busy is 1 leaves its interrupt output at 0.
- R8: A read needs both enable and output enable at 1: with either at 0 a read of its own slot does not clear the interrupt.
- R9: When a set and a clear of the same interrupt fall in the same cycle, the interrupt output ends at 0.
- R10: Writes to a port's own slot, and accesses to any other address, change neither interrupt output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lft_en | input | 1 | Left port access enable, active high |
| lft_we | input | 1 | Left port write strobe (1 write, 0 read) |
| lft_oe | input | 1 | Left port output enable, active high |
| lft_addr | input | ADDR_W | Left port address |
| lft_busy | input | 1 | Left port held off by the arbiter |
| rgt_en | input | 1 | Right port access enable, active high |
| rgt_we | input | 1 | Right port write strobe (1 write, 0 read) |
| rgt_oe | input | 1 | Right port output enable, active high |
| rgt_addr | input | ADDR_W | Right port address |
| rgt_busy | input | 1 | Right port held off by the arbiter |
| lft_irq_n | output | 1 | Left port interrupt, active low |
| rgt_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The hardest situation to reach is a set and a clear of the same interrupt landing in one cycle, since it needs one port writing into a slot while the owner reads that same slot with no busy on either side. The bench forces it directly from a cleared state, so that set-wins is visible as a transition, and the random phase biases both addresses onto the two slot addresses so that such collisions, and busy-masked variants of them, recur many times. Busy and output enable are randomised independently so that masked reads and masked writes appear against a pending interrupt as well as an idle one.

// File: rtl/mbx_pkg.sv
// Package: shared types for the mailbox interrupt controller.
// Assumes all control bits arriving from a port are active high.
package mbx_pkg;

    // Access controls of one port, as sampled on a clock edge.
    typedef struct packed {
        logic en;    // port selected
        logic we;    // 1 = write, 0 = read
        logic oe;    // output enable, needed for reads
        logic busy;  // arbiter holds this port off
    } port_ctl_t;

    localparam int unsigned NUM_PORTS = 2;
    localparam int unsigned LEFT_IDX  = 0;
    localparam int unsigned RIGHT_IDX = 1;

endpackage

// File: rtl/mbx_port_decode.sv
// Module: mbx_port_decode
// Decodes one port's access into two events: a post into the other port's
// slot and a take from its own slot. Busy masks both events.
// Assumes the controls and address are stable around the clock edge.
module mbx_port_decode #(
    parameter int unsigned ADDR_W   = 15,
    parameter bit          OWN_HIGH = 1'b0   // 1: this port owns the top address
) (
    input  mbx_pkg::port_ctl_t ctl,
    input  logic [ADDR_W-1:0]  addr,
    output logic               post_other,
    output logic               take_own
);
    localparam logic [ADDR_W-1:0] SLOT_TOP   = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] SLOT_BELOW = SLOT_TOP - 1'b1;
    localparam logic [ADDR_W-1:0] OWN_SLOT   = OWN_HIGH ? SLOT_TOP : SLOT_BELOW;
    localparam logic [ADDR_W-1:0] PEER_SLOT  = OWN_HIGH ? SLOT_BELOW : SLOT_TOP;

    logic wr_ok;
    logic rd_ok;

    // Qualify a write and a read with enable and the arbiter's busy.
    always_comb begin
        wr_ok = ctl.en && ctl.we && !ctl.busy;
        rd_ok = ctl.en && !ctl.we && ctl.oe && !ctl.busy;
    end

    // Match each qualified access against the slot it can act on.
    always_comb begin
        post_other = wr_ok && (addr == PEER_SLOT);
        take_own   = rd_ok && (addr == OWN_SLOT);
    end
endmodule

// File: rtl/mbx_irq_flag.sv
// Module: mbx_irq_flag
// Holds one pending interrupt. Set has priority over clear.
// Output is registered and active low; reset is synchronous, active low.
module mbx_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_n_o
);
    logic pend_q;

    // Update the pending bit: reset, then set, then clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
        end else if (set_i) begin
            pend_q <= 1'b1;
        end else if (clr_i) begin
            pend_q <= 1'b0;
        end
    end

    // Drive the active-low interrupt pin.
    always_comb irq_n_o = !pend_q;
endmodule

// File: rtl/mbx_irq_ctrl.sv
// Module: mbx_irq_ctrl
// Mailbox interrupt controller for a two-port shared memory. The top address
// is the right port's slot, the one below it the left port's slot. A write to
// the peer's slot raises the peer's interrupt; the owner reading its own slot
// drops it. Busy on a port masks both of that port's actions.
// Assumes one access per port per clock, sampled on the rising edge.
module mbx_irq_ctrl #(
    parameter int unsigned ADDR_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lft_en,
    input  logic              lft_we,
    input  logic              lft_oe,
    input  logic [ADDR_W-1:0] lft_addr,
    input  logic              lft_busy,
    input  logic              rgt_en,
    input  logic              rgt_we,
    input  logic              rgt_oe,
    input  logic [ADDR_W-1:0] rgt_addr,
    input  logic              rgt_busy,
    output logic              lft_irq_n,
    output logic              rgt_irq_n
);
    import mbx_pkg::*;

    port_ctl_t         ctl      [NUM_PORTS];
    logic [ADDR_W-1:0] addr     [NUM_PORTS];
    logic              post     [NUM_PORTS];
    logic              take     [NUM_PORTS];
    logic              irq_n    [NUM_PORTS];

    // Gather the per-port pins into indexed arrays.
    always_comb begin
        ctl[LEFT_IDX]   = '{en: lft_en, we: lft_we, oe: lft_oe, busy: lft_busy};
        ctl[RIGHT_IDX]  = '{en: rgt_en, we: rgt_we, oe: rgt_oe, busy: rgt_busy};
        addr[LEFT_IDX]  = lft_addr;
        addr[RIGHT_IDX] = rgt_addr;
    end

    // One decoder and one flag per port; a flag is set by the peer's post.
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        mbx_port_decode #(
            .ADDR_W   (ADDR_W),
            .OWN_HIGH (p == RIGHT_IDX)
        ) u_dec (
            .ctl        (ctl[p]),
            .addr       (addr[p]),
            .post_other (post[p]),
            .take_own   (take[p])
        );

        mbx_irq_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (post[NUM_PORTS-1-p]),
            .clr_i   (take[p]),
            .irq_n_o (irq_n[p])
        );
    end

    // Return the interrupt pins.
    always_comb begin
        lft_irq_n = irq_n[LEFT_IDX];
        rgt_irq_n = irq_n[RIGHT_IDX];
    end
endmodule

// File: rtl/mbx_irq_ctrl_chk.sv
// Module: mbx_irq_ctrl_chk
// Port-level properties of the mailbox interrupt controller, bound to the top.
// Assumes the same port semantics as the top module.
module mbx_irq_ctrl_chk #(
    parameter int unsigned ADDR_W = 15
) (
    input logic              clk,
    input logic              rst_n,
    input logic              lft_en,
    input logic              lft_we,
    input logic              lft_oe,
    input logic [ADDR_W-1:0] lft_addr,
    input logic              lft_busy,
    input logic              rgt_en,
    input logic              rgt_we,
    input logic              rgt_oe,
    input logic [ADDR_W-1:0] rgt_addr,
    input logic              rgt_busy,
    input logic              lft_irq_n,
    input logic              rgt_irq_n
);
    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] BLW = TOP - 1'b1;

    logic l_sets_r, r_sets_l, r_reads_own, l_reads_own;

    // Events seen from the pins.
    always_comb begin
        l_sets_r    = lft_en && lft_we && !lft_busy && (lft_addr == TOP);
        r_sets_l    = rgt_en && rgt_we && !rgt_busy && (rgt_addr == BLW);
        r_reads_own = rgt_en && !rgt_we && rgt_oe && !rgt_busy && (rgt_addr == TOP);
        l_reads_own = lft_en && !lft_we && lft_oe && !lft_busy && (lft_addr == BLW);
    end

    p_reset_idle_r1: assert property (@(posedge clk)
        !rst_n |=> (lft_irq_n && rgt_irq_n));

    p_set_right_r2: assert property (@(posedge clk) disable iff (!rst_n)
        l_sets_r |=> !rgt_irq_n);

    p_set_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        r_sets_l |=> !lft_irq_n);

    p_clear_right_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (r_reads_own && !l_sets_r) |=> rgt_irq_n);

    p_clear_left_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (l_reads_own && !r_sets_l) |=> lft_irq_n);

    // Covers R5, R7, R8: only a qualified own read drops a pending interrupt.
    p_hold_right_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rgt_irq_n && !r_reads_own) |=> !rgt_irq_n);

    p_hold_left_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!lft_irq_n && !l_reads_own) |=> !lft_irq_n);

    // Covers R6, R10: only a qualified peer write raises an idle interrupt.
    p_idle_right_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rgt_irq_n && !l_sets_r) |=> rgt_irq_n);

    p_idle_left_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lft_irq_n && !r_sets_l) |=> lft_irq_n);
endmodule

bind mbx_irq_ctrl mbx_irq_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lft_en    (lft_en),
    .lft_we    (lft_we),
    .lft_oe    (lft_oe),
    .lft_addr  (lft_addr),
    .lft_busy  (lft_busy),
    .rgt_en    (rgt_en),
    .rgt_we    (rgt_we),
    .rgt_oe    (rgt_oe),
    .rgt_addr  (rgt_addr),
    .rgt_busy  (rgt_busy),
    .lft_irq_n (lft_irq_n),
    .rgt_irq_n (rgt_irq_n)
);

// File: tb/mbx_irq_ctrl_tb_top.sv
// Bench: directed corner cases, then seeded random traffic, against a model.
module mbx_irq_ctrl_tb_top;
    localparam int unsigned AW = 15;
    localparam logic [AW-1:0] TOP = {AW{1'b1}};
    localparam logic [AW-1:0] BLW = TOP - 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lft_en = 0, lft_we = 0, lft_oe = 0, lft_busy = 0;
    logic rgt_en = 0, rgt_we = 0, rgt_oe = 0, rgt_busy = 0;
    logic [AW-1:0] lft_addr = '0, rgt_addr = '0;
    logic lft_irq_n, rgt_irq_n;

    int n_cmp = 0;
    int n_bad = 0;
    logic m_l = 1'b0;   // model: left interrupt pending
    logic m_r = 1'b0;   // model: right interrupt pending

    always #2 clk = !clk;

    mbx_irq_ctrl #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .lft_en(lft_en), .lft_we(lft_we), .lft_oe(lft_oe),
        .lft_addr(lft_addr), .lft_busy(lft_busy),
        .rgt_en(rgt_en), .rgt_we(rgt_we), .rgt_oe(rgt_oe),
        .rgt_addr(rgt_addr), .rgt_busy(rgt_busy),
        .lft_irq_n(lft_irq_n), .rgt_irq_n(rgt_irq_n)
    );

    function automatic logic wr_hit(logic en, logic we, logic busy,
                                    logic [AW-1:0] a, logic [AW-1:0] slot);
        return en && we && !busy && (a == slot);
    endfunction

    function automatic logic rd_hit(logic en, logic we, logic oe, logic busy,
                                    logic [AW-1:0] a, logic [AW-1:0] slot);
        return en && !we && oe && !busy && (a == slot);
    endfunction

    function automatic logic nxt(logic cur, logic set, logic clr);
        return set ? 1'b1 : (clr ? 1'b0 : cur);
    endfunction

    task automatic check(string tag);
        n_cmp++;
        if (lft_irq_n !== !m_l) begin
            n_bad++;
            $display("FAIL %s lft_irq_n actual=%b expected=%b", tag, lft_irq_n, !m_l);
        end
        n_cmp++;
        if (rgt_irq_n !== !m_r) begin
            n_bad++;
            $display("FAIL %s rgt_irq_n actual=%b expected=%b", tag, rgt_irq_n, !m_r);
        end
    endtask

    // Drive one cycle of access (called just after a falling edge), update the
    // model for the next rising edge, then check at the following falling edge.
    task automatic cyc(logic rs,
                       logic le, logic lw, logic lo, logic [AW-1:0] la, logic lb,
                       logic re, logic rw, logic ro, logic [AW-1:0] ra, logic rb,
                       string tag);
        rst_n = rs;
        lft_en = le; lft_we = lw; lft_oe = lo; lft_addr = la; lft_busy = lb;
        rgt_en = re; rgt_we = rw; rgt_oe = ro; rgt_addr = ra; rgt_busy = rb;
        if (!rs) begin
            m_l = 1'b0;
            m_r = 1'b0;
        end else begin
            m_r = nxt(m_r, wr_hit(le, lw, lb, la, TOP), rd_hit(re, rw, ro, rb, ra, TOP));
            m_l = nxt(m_l, wr_hit(re, rw, rb, ra, BLW), rd_hit(le, lw, lo, lb, la, BLW));
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic idle(string tag);
        cyc(1, 0,0,0,'0,0, 0,0,0,'0,0, tag);
    endtask

    function automatic logic [AW-1:0] pick_addr();
        int unsigned r = $urandom % 4;
        if (r == 0) return TOP;
        if (r == 1) return BLW;
        return AW'($urandom);
    endfunction

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        @(negedge clk);
        // R1: reset state
        cyc(0, 0,0,0,'0,0, 0,0,0,'0,0, "R1 reset");
        cyc(0, 1,1,0,TOP,0, 1,1,0,BLW,0, "R1 writes under reset");
        // R2: left posts to right slot
        cyc(1, 1,1,0,TOP,0, 0,0,0,'0,0, "R2 left write top");
        // R5: left reads right's slot, right stays pending
        cyc(1, 1,0,1,TOP,0, 0,0,0,'0,0, "R5 left reads peer slot");
        // R7: busy right cannot clear
        cyc(1, 0,0,0,'0,0, 1,0,1,TOP,1, "R7 busy own read");
        // R8: missing oe or enable
        cyc(1, 0,0,0,'0,0, 1,0,0,TOP,0, "R8 read without oe");
        cyc(1, 0,0,0,'0,0, 0,0,1,TOP,0, "R8 read without enable");
        // R4: right reads own slot
        cyc(1, 0,0,0,'0,0, 1,0,1,TOP,0, "R4 right clears");
        // R6: busy left cannot set
        cyc(1, 1,1,0,TOP,1, 0,0,0,'0,0, "R6 busy peer write");
        // R3: right posts to left slot
        cyc(1, 0,0,0,'0,0, 1,1,0,BLW,0, "R3 right write below-top");
        // R5: right reads left's slot
        cyc(1, 0,0,0,'0,0, 1,0,1,BLW,0, "R5 right reads peer slot");
        // R4: left reads own slot
        cyc(1, 1,0,1,BLW,0, 0,0,0,'0,0, "R4 left clears");
        // R9: set and clear together from idle, both sides
        cyc(1, 1,0,1,BLW,0, 1,1,0,BLW,0, "R9 left set wins");
        cyc(1, 1,1,0,TOP,0, 1,0,1,TOP,0, "R9 right set wins");
        cyc(1, 1,0,1,BLW,0, 1,0,1,TOP,0, "R4 both clear");
        // R10: own-slot writes and other addresses
        cyc(1, 1,1,0,BLW,0, 1,1,0,TOP,0, "R10 own slot writes");
        cyc(1, 1,1,0,TOP-2,0, 1,1,0,'0,0, "R10 other addresses");
        idle("R10 idle");
        // Random mix, busy and oe independent
        for (int i = 0; i < 4000; i++) begin
            cyc(($urandom % 64) != 0,
                $urandom % 2, $urandom % 2, $urandom % 2, pick_addr(), ($urandom % 4) == 0,
                $urandom % 2, $urandom % 2, $urandom % 2, pick_addr(), ($urandom % 4) == 0,
                "R10 random mix");
        end
        // R1: reset with both pending
        cyc(1, 1,1,0,TOP,0, 1,1,0,BLW,0, "R2 set before reset");
        cyc(0, 0,0,0,'0,0, 0,0,0,'0,0, "R1 reset clears pending");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule